// File: doc/BRIEF.md
# Sync-Gated Serial Receive Bit Buffer

This block takes demodulated receive bits, one per `bit_valid` pulse, and decides which of them are kept. While it is hunting, it compares the most recent bits against a synchronization pattern. The pattern is either one programmable byte, or a fixed upper byte of 8'h2D followed by that programmable byte. Once the pattern matches, every later bit is shifted into a 16-bit bit FIFO. A free-running mode skips the hunt and keeps every bit. The host reads the buffered data a byte at a time through a valid/ready read port. An interrupt level tells the host that a programmed number of bits is waiting.

Settings arrive as a 16-bit configuration word on a single-cycle write strobe. The block takes the word only when its upper byte holds the command code 8'hCA. In the lower byte:
- bits 7:4 hold the fill threshold;
- bit 3 selects one-byte (1) or two-byte (0) sync;
- bit 2 selects free-run (1) or sync-gated (0) filling;
- bit 1 enables filling.

Clearing the enable and setting it again drops back to hunting. The block has three states: idle, hunting and filling. It stays in the filling state until the enable bit is cleared.

Flow rules:
- The bit input has no back-pressure. A bit that arrives while the buffer is full is dropped, and the overrun flag records the loss.
- On the read side, `rd_valid` is high while at least 8 bits are held. A byte transfers on a cycle where both `rd_valid` and `rd_ready` are high.
- `rd_data` is stable while `rd_valid` is high and no transfer takes place.

Top module: `rx_sync_fifo`

## Requirements
- R1: A configuration write takes effect only when `cfg_wdata[15:8]` equals 8'hCA. Any other write leaves every setting unchanged.
- R2: After reset the configuration byte is 8'h80: threshold 8, two-byte sync, sync-gated, filling disabled. After reset `irq`, `overrun` and `rd_valid` are low.
- R3: Configuration bits 7:4 set the threshold in bits, and a value of 0 acts as 1. `irq` rises one clock after the held bit count first reaches the threshold, and falls one clock after the count drops below it.
- R4: With bit 3 = 1, hunting ends when the last 8 bits received, earliest first, equal `sync_lo`. The pattern bits are not stored, and the bits after them are.
- R5: With bit 3 = 0, hunting ends only when the last 16 bits equal 8'h2D followed by `sync_lo`. `sync_lo` alone does not end the hunt.
- R6: With bit 2 = 1, every bit received after enabling is stored, with no sync search.
- R7: With bit 1 = 0, once the new setting is in place received bits are not stored.
- R8: Clearing bit 1 and then setting it again returns the block to hunting. A full sync pattern is needed again before any bit is stored.
- R9: A bit that arrives while 16 bits are held is dropped and sets `overrun`. The bits already held are kept.
- R10: `rd_data[7]` is the oldest held bit. A read handshake removes those 8 bits, and it also clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Command code (upper byte) and settings (lower byte) |
| sync_lo | input | 8 | Programmable sync byte |
| bit_valid | input | 1 | A received bit is present this cycle |
| bit_in | input | 1 | Received bit |
| rd_valid | output | 1 | At least one byte is held |
| rd_ready | input | 1 | Host accepts the byte |
| rd_data | output | 8 | Oldest held byte, earliest bit in bit 7 |
| irq | output | 1 | Held bit count is at or above the threshold |
| overrun | output | 1 | A received bit was dropped because the buffer was full |

## Verification
The bench builds the block with its default parameters: a 16-bit buffer, 8-bit reads and a fixed upper sync byte of 8'h2D. With a 16-bit buffer, two bytes fill it, so overrun, read ordering across two bytes and the falling edge of `irq` can all be reached in a few dozen cycles. The 16-bit match window lets the bench check both one-byte and two-byte sync. It also sends noise that contains the programmable byte alone, which must not start filling.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_FILL} rx_state_t;
  localparam logic [7:0] CMD_CODE  = 8'hCA;
  localparam logic [7:0] CFG_RESET = 8'h80;
  typedef struct packed {
    logic [3:0] thr;
    logic       byte_sync;
    logic       free_run;
    logic       en;
    logic       spare;
  } cfg_t;
endpackage

// File: rtl/rxs_cfg_reg.sv
module rxs_cfg_reg
  import rxs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output cfg_t        cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)                         cfg <= cfg_t'(CFG_RESET);
    else if (we && wdata[15:8] == CMD_CODE) cfg <= cfg_t'(wdata[7:0]);
  end
endmodule

// File: rtl/rxs_sync_hunt.sv
module rxs_sync_hunt
  import rxs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_HI = 8'h2D,
  localparam int WIN_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              free_run,
  input  logic              byte_sync,
  input  logic [BYTE_W-1:0] sync_lo,
  input  logic              bit_valid,
  input  logic              bit_in,
  output rx_state_t         state
);
  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] win_next;
  logic             hit;

  assign win_next = {win[WIN_W-2:0], bit_in};

  always_comb begin
    if (byte_sync) hit = (win_next[BYTE_W-1:0] == sync_lo);
    else           hit = (win_next == {SYNC_HI, sync_lo});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      win   <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          win <= '0;
          if (en) state <= free_run ? RX_FILL : RX_HUNT;
        end
        RX_HUNT: begin
          if (!en) state <= RX_IDLE;
          else if (free_run) state <= RX_FILL;
          else if (bit_valid) begin
            win <= win_next;
            if (hit) state <= RX_FILL;
          end
        end
        RX_FILL: if (!en) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxs_bit_fifo.sv
module rxs_bit_fifo #(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_bit,
  input  logic              pop,
  input  logic [3:0]        thr,
  output logic [CNT_W-1:0]  count,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq,
  output logic              overrun
);
  logic [DEPTH-1:0] store;
  logic [DEPTH-1:0] shifted;
  logic [CNT_W-1:0] shamt;
  logic [CNT_W-1:0] thr_eff;
  logic             full;
  logic             do_pop;
  logic             accept;

  assign full     = (count == CNT_W'(DEPTH));
  assign rd_valid = (count >= CNT_W'(BYTE_W));
  assign do_pop   = pop && rd_valid;
  assign accept   = push && (!full || do_pop);
  assign shamt    = rd_valid ? count - CNT_W'(BYTE_W) : '0;
  assign shifted  = store >> shamt;
  assign rd_data  = shifted[BYTE_W-1:0];
  assign thr_eff  = (thr == 4'd0) ? CNT_W'(1) : CNT_W'(thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store   <= '0;
      count   <= '0;
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (accept) store <= {store[DEPTH-2:0], push_bit};
      count <= count + CNT_W'(accept) - (do_pop ? CNT_W'(BYTE_W) : '0);
      irq   <= (count >= thr_eff);
      if (do_pop)            overrun <= 1'b0;
      else if (push && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_HI = 8'h2D,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  input  logic [BYTE_W-1:0] sync_lo,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq,
  output logic              overrun
);
  cfg_t             cfg_q;
  rx_state_t        state;
  logic [CNT_W-1:0] fill_count;
  logic             rd_fire;
  logic             push;

  assign rd_fire = rd_valid && rd_ready;
  assign push    = bit_valid && (state == RX_FILL);

  rxs_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg_q)
  );

  rxs_sync_hunt #(.BYTE_W(BYTE_W), .SYNC_HI(SYNC_HI)) u_hunt (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .free_run(cfg_q.free_run),
    .byte_sync(cfg_q.byte_sync), .sync_lo(sync_lo), .bit_valid(bit_valid),
    .bit_in(bit_in), .state(state)
  );

  rxs_bit_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_bit(bit_in), .pop(rd_fire),
    .thr(cfg_q.thr), .count(fill_count), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq), .overrun(overrun)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [15:0]      cfg_wdata,
  input cfg_t             cfg_q,
  input rx_state_t        state,
  input logic [CNT_W-1:0] fill_count,
  input logic             bit_valid,
  input logic             rd_fire,
  input logic             irq,
  input logic             overrun
);
  p_cfg_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[15:8] != CMD_CODE) |=> $stable(cfg_q));

  p_irq_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.thr != 4'd0 && fill_count >= CNT_W'(cfg_q.thr)) |=> irq);

  p_irq_zero_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.thr == 4'd0 && fill_count != '0) |=> irq);

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && !rd_fire) |=> $stable(fill_count));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_W'(DEPTH));

  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == CNT_W'(DEPTH) && bit_valid && state == RX_FILL && !rd_fire)
      |=> overrun);

  p_overrun_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !overrun);
endmodule

bind rx_sync_fifo rxs_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_q(cfg_q), .state(state), .fill_count(fill_count),
  .bit_valid(bit_valid), .rd_fire(rd_fire), .irq(irq), .overrun(overrun)
);

// File: tb/test_rx_sync_fifo.sv
module test_rx_sync_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  sync_lo = 8'hD4;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        irq;
  logic        overrun;

  int checks = 0;
  int failures = 0;
  bit exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_sync_fifo i_rx_sync_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sync_lo(sync_lo), .bit_valid(bit_valid), .bit_in(bit_in),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .irq(irq), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // driver: sends a byte earliest bit first, pushes stored bits to the scoreboard
  task automatic send_byte(input logic [7:0] b, input bit store);
    for (int i = 7; i >= 0; i--) begin
      bit_valid = 1'b1; bit_in = b[i];
      if (store) exp_q.push_back(b[i]);
      @(negedge clk);
    end
    bit_valid = 1'b0;
  endtask

  // monitor side: pops the expected byte and compares it with the port
  task automatic read_byte(input string req);
    logic [7:0] e;
    chk({req, " rd_valid"}, 16'(rd_valid), 16'd1);
    e = '0;
    for (int i = 7; i >= 0; i--) e[i] = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
    chk({req, " rd_data"}, 16'(rd_data), 16'(e));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 irq", 16'(irq), 16'd0);
    chk("R2 overrun", 16'(overrun), 16'd0);
    chk("R2 rd_valid", 16'(rd_valid), 16'd0);
    // R7 / R2: default disabled, bits not stored
    send_byte(8'h2D, 0); send_byte(8'hD4, 0); send_byte(8'h11, 0);
    @(negedge clk);
    chk("R7 disabled rd_valid", 16'(rd_valid), 16'd0);
    chk("R2 disabled irq", 16'(irq), 16'd0);
    // R1 wrong command code ignored
    write_cfg(16'h1286);
    send_byte(8'hFF, 0);
    @(negedge clk);
    chk("R1 wrong code rd_valid", 16'(rd_valid), 16'd0);
    // R6 free run, R3 irq timing at threshold 8
    write_cfg(16'hCA86);
    send_byte(8'hA5, 1);
    chk("R3 irq not yet", 16'(irq), 16'd0);
    @(negedge clk);
    chk("R3 irq one cycle later", 16'(irq), 16'd1);
    read_byte("R6 free run");
    @(negedge clk);
    chk("R3 irq falls", 16'(irq), 16'd0);
    // R7 disabling stops storage
    write_cfg(16'hCA84);
    send_byte(8'h0F, 0);
    chk("R7 rd_valid after disable", 16'(rd_valid), 16'd0);
    // R3 threshold 0 acts as 1
    write_cfg(16'hCA06);
    bit_valid = 1'b1; bit_in = 1'b0; exp_q.push_back(1'b0);
    @(negedge clk);
    bit_valid = 1'b0;
    @(negedge clk);
    chk("R3 zero threshold irq", 16'(irq), 16'd1);
    for (int i = 6; i >= 0; i--) begin
      bit_valid = 1'b1; bit_in = 1'(8'h3C >> i); exp_q.push_back(1'(8'h3C >> i));
      @(negedge clk);
    end
    bit_valid = 1'b0;
    read_byte("R3 zero threshold data");
    // R5 two-byte sync
    write_cfg(16'hCA80);
    write_cfg(16'hCA82);
    send_byte(8'hFF, 0); send_byte(8'hD4, 0); send_byte(8'h5A, 0);
    chk("R5 low byte alone no sync", 16'(rd_valid), 16'd0);
    send_byte(8'h2D, 0); send_byte(8'hD4, 0); send_byte(8'h96, 1);
    read_byte("R5 word sync data");
    // R4 one-byte sync
    sync_lo = 8'h3C;
    write_cfg(16'hCA88);
    write_cfg(16'hCA8A);
    send_byte(8'h00, 0); send_byte(8'h3C, 0); send_byte(8'hC3, 1);
    read_byte("R4 byte sync data");
    // R8 re-arm requires new sync
    write_cfg(16'hCA88);
    write_cfg(16'hCA8A);
    send_byte(8'h77, 0);
    chk("R8 re-armed hunting", 16'(rd_valid), 16'd0);
    send_byte(8'h3C, 0); send_byte(8'h5A, 1);
    read_byte("R8 after new sync");
    // R9 overrun, R10 order and clear
    write_cfg(16'hCA80);
    write_cfg(16'hCA86);
    send_byte(8'h12, 1); send_byte(8'h34, 1);
    chk("R9 no overrun at full", 16'(overrun), 16'd0);
    bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    chk("R9 overrun set", 16'(overrun), 16'd1);
    read_byte("R10 oldest byte first");
    chk("R10 overrun cleared", 16'(overrun), 16'd0);
    read_byte("R9 held data kept");
    @(negedge clk);
    chk("R10 empty after reads", 16'(rd_valid), 16'd0);
    chk("R3 irq low when empty", 16'(irq), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule